// File: doc/BRIEF.md
# Binary Chip-Count Summer

This block merges the spread-spectrum chips of many synchronized sources into one binary word per chip clock. Each source presents one chip per cycle, either +1 or -1. The block counts the sources whose chip is +1 and puts that count on a single shared result bus, which every receiver watches. Chips at -1 add nothing to the count. Sending the count of positive chips instead of the signed sum keeps the bus purely binary. A receiver can rebuild the signed sum as 2*count - N.

Inside, the block is a flow-through population counter. An input register stage is followed by a balanced adder tree with one register rank per tree level. It accepts a new chip vector on every clock and never stalls. A valid flag travels with each vector through the same register stages. The number of sources N is a parameter. The count width and the pipeline depth are derived from N.

Top module: `chipsum_top`

## Requirements
- R1: Chip encoding is one bit per source: 1 means +1 and 0 means -1. `sum_count` equals the number of 1 bits in the accepted `chip_vec`.
- R2: A vector in which every source sends -1 (all bits 0) produces a count of 0.
- R3: A vector in which every source sends +1 (all bits 1) produces a count of N.
- R4: The latency is ceil(log2 N) + 1 clock cycles. A vector presented before rising edge e appears on the outputs after rising edge e + ceil(log2 N).
- R5: A new vector is accepted on every cycle. Back-to-back vectors each give their own count, in input order, with no stall and no skipped cycle.
- R6: `sum_valid` repeats `chip_valid` delayed by exactly the latency of R4. Gaps in the valid stream are preserved cycle for cycle.
- R7: While `rst` is high, every rising edge clears the pipeline. After any reset edge, `sum_valid` is 0 and `sum_count` is 0 until new data arrives through the pipeline.
- R8: `sum_count` is ceil(log2(N+1)) bits wide and never exceeds N.
- R9: The count depends only on how many sources are positive, not on which ones are positive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_valid | input | 1 | Marks `chip_vec` as a live chip vector this cycle |
| chip_vec | input | N | One chip per source; 1 means +1 and 0 means -1 |
| sum_valid | output | 1 | Marks `sum_count` as the result of a live vector |
| sum_count | output | ceil(log2(N+1)) | Number of sources that sent +1 |

## Verification
Every vector passes through the same ceil(log2 N)+1 register ranks. A wrong partial sum at any tree level therefore shows up as a wrong `sum_count` exactly that many cycles after the offending vector, and it affects only that one result. A valid bit that is dropped or repeated at any rank shows up as a shifted or missing `sum_valid` pulse at the same point in time. The bench drives the input with every possible chip pattern of a seven-source configuration, both back-to-back and with gaps. It also resets the block while the pipeline is full. As a result, any adder, lane or delay fault reaches the ports within four cycles of the vector that exposes it.

// File: rtl/chipsum_pkg.sv
package chipsum_pkg;

    // One bit per source on the chip input.
    typedef enum logic {
        CHIP_NEG = 1'b0,   // -1 chip
        CHIP_POS = 1'b1    // +1 chip
    } chip_e;

    // Number of binary-tree levels needed to reduce n leaves to one node.
    function automatic int unsigned tree_levels(input int unsigned n);
        int unsigned lv;
        lv = 0;
        for (int i = 0; i < 31; i++) begin
            if ((32'd1 << i) < n) lv = i + 1;
        end
        return lv;
    endfunction

    // Bits needed to hold any count from 0 to n.
    function automatic int unsigned count_width(input int unsigned n);
        int unsigned w;
        w = tree_levels(n + 1);
        return (w == 0) ? 1 : w;
    endfunction

endpackage

// File: rtl/chipsum_ingest.sv
module chipsum_ingest
    import chipsum_pkg::*;
#(
    parameter int unsigned N = 16,
    parameter int unsigned P = 16,
    parameter int unsigned W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [N-1:0]     in_chips,
    output logic             out_valid,
    output logic [P*W-1:0]   leaves
);

    logic [P*W-1:0] leaves_d;

    for (genvar i = 0; i < P; i++) begin : g_lane
        if (i < N) begin : g_live
            assign leaves_d[i*W +: W] = W'(chip_e'(in_chips[i]) == CHIP_POS);
        end else begin : g_pad
            // Lanes beyond N behave as sources fixed at -1.
            assign leaves_d[i*W +: W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            leaves    <= '0;
        end else begin
            out_valid <= in_valid;
            leaves    <= leaves_d;
        end
    end

    logic [W-1:0] leaf_total;
    always_comb begin
        leaf_total = '0;
        for (int i = 0; i < P; i++) leaf_total += leaves[i*W +: W];
    end

    // R1: registered leaves carry exactly the positive-chip count of the input
    p_ingest_popcount_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (32'(leaf_total) == $past($countones(in_chips))));

    // R6: valid moves one stage per cycle
    p_ingest_valid_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

endmodule

// File: rtl/chipsum_adder_level.sv
module chipsum_adder_level #(
    parameter int unsigned NODES_IN = 2,
    parameter int unsigned W        = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [NODES_IN*W-1:0]       in_nodes,
    output logic                        out_valid,
    output logic [(NODES_IN/2)*W-1:0]   out_nodes
);

    localparam int unsigned NODES_OUT = NODES_IN / 2;

    logic [NODES_OUT*W-1:0] sums_d;

    for (genvar j = 0; j < NODES_OUT; j++) begin : g_pair
        assign sums_d[j*W +: W] = in_nodes[(2*j)*W +: W] + in_nodes[(2*j+1)*W +: W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_nodes <= '0;
        end else begin
            out_valid <= in_valid;
            out_nodes <= sums_d;
        end
    end

    logic [W-1:0] total_in, total_out;
    always_comb begin
        total_in = '0;
        for (int i = 0; i < NODES_IN; i++) total_in += in_nodes[i*W +: W];
        total_out = '0;
        for (int i = 0; i < NODES_OUT; i++) total_out += out_nodes[i*W +: W];
    end

    // R1: a tree level neither loses nor invents positive chips
    p_level_conserve_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (total_out == $past(total_in)));

    // R6: valid advances with its data by one cycle
    p_level_valid_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

endmodule

// File: rtl/chipsum_top.sv
module chipsum_top
    import chipsum_pkg::*;
#(
    parameter int unsigned N = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        chip_valid,
    input  logic [N-1:0]                chip_vec,
    output logic                        sum_valid,
    output logic [count_width(N)-1:0]   sum_count
);

    localparam int unsigned LEVELS = tree_levels(N);
    localparam int unsigned P      = 1 << LEVELS;
    localparam int unsigned W      = count_width(N);

    logic           leaf_v;
    logic [P*W-1:0] leaves;

    chipsum_ingest #(.N(N), .P(P), .W(W)) u_ingest (
        .clk      (clk),
        .rst      (rst),
        .in_valid (chip_valid),
        .in_chips (chip_vec),
        .out_valid(leaf_v),
        .leaves   (leaves)
    );

    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
        localparam int unsigned NIN = P >> k;
        logic [NIN*W-1:0]     src_nodes;
        logic                 src_v;
        logic [(NIN/2)*W-1:0] nodes;
        logic                 v;

        if (k == 0) begin : g_first
            assign src_nodes = leaves;
            assign src_v     = leaf_v;
        end else begin : g_next
            assign src_nodes = g_lvl[k-1].nodes;
            assign src_v     = g_lvl[k-1].v;
        end

        chipsum_adder_level #(.NODES_IN(NIN), .W(W)) u_add (
            .clk      (clk),
            .rst      (rst),
            .in_valid (src_v),
            .in_nodes (src_nodes),
            .out_valid(v),
            .out_nodes(nodes)
        );
    end

    if (LEVELS == 0) begin : g_single
        assign sum_count = leaves;
        assign sum_valid = leaf_v;
    end else begin : g_tree
        assign sum_count = g_lvl[LEVELS-1].nodes;
        assign sum_valid = g_lvl[LEVELS-1].v;
    end

    // R8: the broadcast count stays within the number of sources
    p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
        sum_valid |-> (32'(sum_count) <= N));

    // R7: a reset edge leaves the result bus idle and zero
    p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sum_valid && (sum_count == '0)));

endmodule

// File: tb/chipsum_top_test.sv
`timescale 1ns/1ps
module chipsum_top_test;

    localparam int N   = 7;
    localparam int W   = 3;   // ceil(log2(7+1))
    localparam int LAT = 4;   // ceil(log2 7) + 1

    logic         clk = 1'b0;
    logic         rst;
    logic         chip_valid;
    logic [N-1:0] chip_vec;
    logic         sum_valid;
    logic [W-1:0] sum_count;

    always #2.5 clk = ~clk;

    chipsum_top #(.N(N)) uut (
        .clk       (clk),
        .rst       (rst),
        .chip_valid(chip_valid),
        .chip_vec  (chip_vec),
        .sum_valid (sum_valid),
        .sum_count (sum_count)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    int cyc;
    int hist_v [0:4095];
    int hist_c [0:4095];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int ones(input logic [N-1:0] v);
        int s = 0;
        for (int i = 0; i < N; i++) s += (v[i] ? 1 : 0);
        return s;
    endfunction

    // One chip cycle: compare outputs with the vector from LAT cycles ago, then drive.
    task automatic step(input bit v, input logic [N-1:0] vec);
        int ev, ec;
        @(negedge clk);
        if (cyc >= LAT) begin
            ev = hist_v[cyc-LAT];
            ec = hist_c[cyc-LAT];
        end else begin
            ev = 0;
            ec = 0;
        end
        check(int'(sum_valid) == ev, "R4/R6 valid", int'(sum_valid), ev);
        check(int'(sum_count) <= N, "R8 bound", int'(sum_count), N);
        if (ev == 1 || cyc < LAT) begin
            if (ec == 0)      check(int'(sum_count) == ec, "R2 count", int'(sum_count), ec);
            else if (ec == N) check(int'(sum_count) == ec, "R3 count", int'(sum_count), ec);
            else              check(int'(sum_count) == ec, "R1 R5 R9 count", int'(sum_count), ec);
        end
        chip_valid = v;
        chip_vec   = vec;
        hist_v[cyc] = v ? 1 : 0;
        hist_c[cyc] = ones(vec);
        cyc++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        chip_valid = 1'b0;
        chip_vec = '0;
        repeat (2) @(negedge clk);
        // R7: outputs cleared while reset is held
        check(sum_valid == 1'b0, "R7 valid", int'(sum_valid), 0);
        check(sum_count == '0, "R7 count", int'(sum_count), 0);
        rst = 1'b0;
        cyc = 0;
    endtask

    initial begin
        rst = 1'b1;
        chip_valid = 1'b0;
        chip_vec = '0;
        cyc = 0;
        repeat (3) @(posedge clk);
        do_reset();

        // Exhaustive sweep, back-to-back (R1 R5 R9, with R2 and R3 at the ends)
        for (int i = 0; i < (1 << N); i++) step(1'b1, N'(i));

        // Second sweep with gaps in valid and scrambled patterns (R6)
        for (int i = 0; i < (1 << N); i++) step((i % 3) != 0, N'(i ^ 7'h55));

        // Isolated pulse after idle: latency (R4)
        for (int i = 0; i < 6; i++) step(1'b0, '0);
        step(1'b1, '1);
        for (int i = 0; i < 6; i++) step(1'b0, '1);

        // Alternate all -1 and all +1 (R2 R3)
        for (int i = 0; i < 10; i++) step(1'b1, (i % 2) ? '1 : '0);

        // Reset with a full pipeline (R7)
        for (int i = 0; i < 3; i++) step(1'b1, '1);
        do_reset();
        for (int i = 0; i < 20; i++) step(1'b1, N'(i * 5 + 3));
        for (int i = 0; i < LAT + 1; i++) step(1'b0, '0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule